// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This block adds or subtracts two 128-bit vectors lane by lane and clamps every lane to the range of its type instead of letting it wrap. A run-time size code cuts the vectors into sixteen byte lanes, eight halfword lanes or four word lanes. Two further selects choose between a signed and an unsigned interpretation and between addition and subtraction. Each lane forms the exact result one bit wider than the lane and then limits it to the lane's minimum or maximum.

The output is registered. An operation presented with `valid_i` appears one cycle later with `valid_o`. Alongside the result the block returns one saturation flag per byte position. A lane that was clamped raises the flags of all its bytes. A size code with no lane width behind it raises an error instead of producing a result.

Top module: `psat_unit`

## Requirements
- R1: `size_i` selects the lane width: 0 gives sixteen 8-bit lanes, 1 gives eight 16-bit lanes and 2 gives four 32-bit lanes. Lane k occupies bits [k*w +: w] of every vector, where w is the lane width.
- R2: When the exact lane result lies inside the lane's range, the output lane equals that exact result and the lane's flags stay low.
- R3: With `unsigned_i`=0, lanes are two's-complement values, and results are limited to [-2^(w-1), 2^(w-1)-1].
- R4: With `unsigned_i`=1 and `sub_i`=0, a lane sum above 2^w-1 yields all ones.
- R5: With `unsigned_i`=1 and `sub_i`=1, a lane difference below zero yields 0.
- R6: With `sub_i`=1, each lane computes `op_n_i` minus `op_m_i`. With `sub_i`=0, it adds them.
- R7: Bit j of `sat_o` (byte j) is 1 exactly when the lane containing byte j was clamped. For 16-bit and 32-bit lanes, the flag is the same across all bytes of the lane.
- R8: `valid_o` is 1 in the cycle after a cycle with `valid_i`=1. `result_o`, `sat_o` and `err_o` for that operation are presented in that same cycle.
- R9: An operation with `size_i`=3 gives `err_o`=1, `result_o`=0 and `sat_o`=0. Legal size codes give `err_o`=0.
- R10: In a cycle with `valid_i`=0, the next cycle has `valid_o`=0 and `err_o`=0. `result_o` and `sat_o` keep their previous values.
- R11: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| size_i | input | 2 | Lane size code (0: 8-bit, 1: 16-bit, 2: 32-bit, 3: illegal) |
| unsigned_i | input | 1 | 1 selects unsigned lanes, 0 selects signed lanes |
| sub_i | input | 1 | 1 selects n minus m, 0 selects n plus m |
| op_n_i | input | 128 | First operand vector |
| op_m_i | input | 128 | Second operand vector |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| result_o | output | 128 | Saturated result vector |
| sat_o | output | 16 | Per-byte saturation flags |
| err_o | output | 1 | Illegal size code seen on the operation |

## Verification
The only state in the block is the output register stage. A wrong internal value therefore shows at the ports exactly one cycle after the strobe. Three kinds of error are possible there: a bad clamp, a lost carry between the bytes of a wide lane, or a flag that is not replicated across its lane. An exhaustive byte-lane sweep covers every operand pair in all four sign and direction modes. Corner-heavy vectors cover the halfword and word lanes, so a wrong clamp boundary or a wrong lane slice changes a compared result within one operation.

// File: rtl/psat_pkg.sv
`timescale 1ns/1ps
package psat_pkg;
  typedef enum logic [1:0] {
    SZ_B8  = 2'd0,
    SZ_B16 = 2'd1,
    SZ_B32 = 2'd2,
    SZ_BAD = 2'd3
  } lane_sz_e;

  localparam int NUM_SIZES = 3;
endpackage

// File: rtl/psat_lane.sv
`timescale 1ns/1ps
module psat_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         uns_i,
  input  logic         sub_i,
  output logic [W-1:0] y_o,
  output logic         sat_o
);
  logic [W:0] ea, eb, ex;

  // one guard bit: sign or zero extension
  assign ea = {~uns_i & a_i[W-1], a_i};
  assign eb = {~uns_i & b_i[W-1], b_i};
  assign ex = sub_i ? (ea - eb) : (ea + eb);

  always_comb begin
    sat_o = uns_i ? ex[W] : (ex[W] ^ ex[W-1]);
    if (!sat_o)      y_o = ex[W-1:0];
    else if (uns_i)  y_o = sub_i ? '0 : '1;
    else if (ex[W])  y_o = {1'b1, {(W-1){1'b0}}};
    else             y_o = {1'b0, {(W-1){1'b1}}};
  end

  always_comb begin
    if (uns_i && sub_i)  a_r5_usub_not_above_n: assert (y_o <= a_i);
    if (uns_i && !sub_i) a_r4_uadd_not_below_n: assert (y_o >= a_i);
  end
endmodule

// File: rtl/psat_lane_array.sv
`timescale 1ns/1ps
module psat_lane_array #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0]   n_i,
  input  logic [VEC_W-1:0]   m_i,
  input  logic               uns_i,
  input  logic               sub_i,
  output logic [VEC_W-1:0]   res_o,
  output logic [VEC_W/8-1:0] flg_o
);
  localparam int NL  = VEC_W / LANE_W;
  localparam int BPL = LANE_W / 8;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic sat;
    psat_lane #(.W(LANE_W)) u_lane (
      .a_i   (n_i[l*LANE_W +: LANE_W]),
      .b_i   (m_i[l*LANE_W +: LANE_W]),
      .uns_i (uns_i),
      .sub_i (sub_i),
      .y_o   (res_o[l*LANE_W +: LANE_W]),
      .sat_o (sat)
    );
    assign flg_o[l*BPL +: BPL] = {BPL{sat}};
  end
endmodule

// File: rtl/psat_unit.sv
`timescale 1ns/1ps
module psat_unit
  import psat_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [1:0]         size_i,
  input  logic               unsigned_i,
  input  logic               sub_i,
  input  logic [VEC_W-1:0]   op_n_i,
  input  logic [VEC_W-1:0]   op_m_i,
  output logic               valid_o,
  output logic [VEC_W-1:0]   result_o,
  output logic [VEC_W/8-1:0] sat_o,
  output logic               err_o
);
  localparam int NBYTES = VEC_W / 8;

  function automatic logic [NBYTES-1:0] stride_mask(int stride);
    logic [NBYTES-1:0] mk;
    mk = '0;
    for (int i = 0; i < NBYTES; i += stride) mk[i] = 1'b1;
    return mk;
  endfunction

  localparam logic [NBYTES-1:0] M2 = stride_mask(2);
  localparam logic [NBYTES-1:0] M4 = stride_mask(4);

  logic [VEC_W-1:0]  res_g [NUM_SIZES];
  logic [NBYTES-1:0] flg_g [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    psat_lane_array #(.VEC_W(VEC_W), .LANE_W(8 << g)) u_arr (
      .n_i   (op_n_i),
      .m_i   (op_m_i),
      .uns_i (unsigned_i),
      .sub_i (sub_i),
      .res_o (res_g[g]),
      .flg_o (flg_g[g])
    );
  end

  logic [VEC_W-1:0]  res_d;
  logic [NBYTES-1:0] flg_d;
  logic              bad_d;

  always_comb begin
    bad_d = 1'b0;
    unique case (lane_sz_e'(size_i))
      SZ_B8:  begin res_d = res_g[0]; flg_d = flg_g[0]; end
      SZ_B16: begin res_d = res_g[1]; flg_d = flg_g[1]; end
      SZ_B32: begin res_d = res_g[2]; flg_d = flg_g[2]; end
      default: begin res_d = '0; flg_d = '0; bad_d = 1'b1; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
      result_o <= '0;
      sat_o    <= '0;
    end else begin
      valid_o <= valid_i;
      err_o   <= valid_i & bad_d;
      if (valid_i) begin
        result_o <= res_d;
        sat_o    <= flg_d;
      end
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r10_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !err_o && $stable(result_o) && $stable(sat_o)));

  a_r9_illegal_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == SZ_BAD) |=> (err_o && result_o == '0 && sat_o == '0));

  a_r9_legal_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i != SZ_BAD) |=> !err_o);

  a_r7_half_flags_paired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == SZ_B16) |=> (((sat_o & M2) << 1) == (sat_o & (M2 << 1))));

  a_r7_word_flags_grouped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == SZ_B32) |=>
      ((((sat_o & M4) << 1) == (sat_o & (M4 << 1))) &&
       (((sat_o & M4) << 2) == (sat_o & (M4 << 2))) &&
       (((sat_o & M4) << 3) == (sat_o & (M4 << 3)))));
endmodule

// File: tb/psat_unit_tb.sv
`timescale 1ns/1ps
module psat_unit_tb;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   size_i = '0;
  logic         unsigned_i = 1'b0;
  logic         sub_i = 1'b0;
  logic [127:0] op_n_i = '0;
  logic [127:0] op_m_i = '0;
  logic         valid_o;
  logic [127:0] result_o;
  logic [15:0]  sat_o;
  logic         err_o;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  psat_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .size_i(size_i),
    .unsigned_i(unsigned_i), .sub_i(sub_i), .op_n_i(op_n_i), .op_m_i(op_m_i),
    .valid_o(valid_o), .result_o(result_o), .sat_o(sat_o), .err_o(err_o)
  );

  function automatic void model(input logic [127:0] n, input logic [127:0] m,
                                input logic [1:0] sz, input logic uns, input logic sub,
                                output logic [127:0] y, output logic [15:0] f,
                                output logic e);
    int w;
    longint msk, a, b, r, lo, hi;
    y = '0; f = '0; e = 1'b0;
    if (sz == 2'd3) begin
      e = 1'b1;
      return;
    end
    w = 8 << sz;
    msk = (64'sd1 <<< w) - 1;
    for (int l = 0; l < 128 / w; l++) begin
      a = longint'(n >> (l * w)) & msk;
      b = longint'(m >> (l * w)) & msk;
      if (uns) begin
        lo = 0; hi = msk;
      end else begin
        lo = -((msk + 1) / 2); hi = (msk + 1) / 2 - 1;
        if (a > hi) a = a - (msk + 1);
        if (b > hi) b = b - (msk + 1);
      end
      r = sub ? (a - b) : (a + b);
      if (r < lo || r > hi) begin
        r = (r < lo) ? lo : hi;
        for (int j = l * w / 8; j < (l + 1) * w / 8; j++) f[j] = 1'b1;
      end
      y = y | (128'(r & msk) << (l * w));
    end
  endfunction

  task automatic run_op(input string req, input logic [127:0] n, input logic [127:0] m,
                        input logic [1:0] sz, input logic uns, input logic sub);
    logic [127:0] ey;
    logic [15:0]  ef;
    logic         ee;
    @(negedge clk);
    op_n_i = n; op_m_i = m; size_i = sz; unsigned_i = uns; sub_i = sub; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    model(n, m, sz, uns, sub, ey, ef, ee);
    n_checks++;
    if (valid_o !== 1'b1 || result_o !== ey || sat_o !== ef || err_o !== ee) begin
      n_fail++;
      $display("FAIL %s sz=%0d uns=%0b sub=%0b: got v=%0b y=%h f=%h e=%0b, exp v=1 y=%h f=%h e=%0b",
               req, sz, uns, sub, valid_o, result_o, sat_o, err_o, ey, ef, ee);
    end
  endtask

  function automatic logic [31:0] corner(int w, int k);
    logic [31:0] v;
    case (k % 7)
      0: v = 32'd0;
      1: v = 32'd1;
      2: v = (32'd1 << (w - 1)) - 1;
      3: v = 32'd1 << (w - 1);
      4: v = 32'hFFFF_FFFF;
      5: v = (32'd1 << (w - 1)) + 1;
      default: v = $urandom;
    endcase
    return (w == 32) ? v : (v & ((32'd1 << w) - 1));
  endfunction

  task automatic sweep_wide(input logic [1:0] sz, input int count);
    int w;
    logic [127:0] n, m;
    w = 8 << sz;
    for (int md = 0; md < 4; md++) begin
      for (int it = 0; it < count; it++) begin
        n = '0; m = '0;
        for (int l = 0; l < 128 / w; l++) begin
          n = n | (128'(corner(w, $urandom_range(0, 6))) << (l * w));
          m = m | (128'(corner(w, $urandom_range(0, 6))) << (l * w));
        end
        run_op(sz == 2'd1 ? "R1_R3_R4_R5_R7 half" : "R1_R3_R4_R5_R7 word",
               n, m, sz, md[1], md[0]);
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] hold_y;
    logic [15:0]  hold_f;
    repeat (3) @(negedge clk);
    // R11 reset state
    n_checks++;
    if (valid_o !== 1'b0 || result_o !== '0 || sat_o !== '0 || err_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 reset: got v=%0b y=%h f=%h e=%0b, exp all 0",
               valid_o, result_o, sat_o, err_o);
    end
    rst_ni = 1'b1;

    // R2 R6 small in-range values, ordering of n minus m
    run_op("R2_R6 sub order", {16{8'd9}}, {16{8'd4}}, 2'd0, 1'b0, 1'b1);
    run_op("R2_R6 usub order", {8{16'd300}}, {8{16'd100}}, 2'd1, 1'b1, 1'b1);
    run_op("R2 add word", {4{32'd70000}}, {4{32'd5}}, 2'd2, 1'b1, 1'b0);
    run_op("R1 lane position", 128'h0001_0203_0405_0607_0809_0A0B_0C0D_0E0F,
           128'h7F00_0000_0000_0000_0000_0000_0000_0080, 2'd0, 1'b0, 1'b0);
    run_op("R4 uadd word carry", {4{32'hFFFF_FFF0}}, {4{32'h20}}, 2'd2, 1'b1, 1'b0);
    run_op("R5 usub half below", {8{16'd1}}, {8{16'd2}}, 2'd1, 1'b1, 1'b1);
    run_op("R3 signed word min", {4{32'h8000_0000}}, {4{32'd1}}, 2'd2, 1'b0, 1'b1);

    // R2 R3 R4 R5 R6 R7 exhaustive over byte lanes
    for (int md = 0; md < 4; md++)
      for (int a = 0; a < 256; a++)
        for (int blk = 0; blk < 16; blk++) begin
          logic [127:0] m;
          for (int l = 0; l < 16; l++) m[l*8 +: 8] = 8'(blk * 16 + l);
          run_op("R2_R3_R4_R5_R6_R7 byte sweep", {16{8'(a)}}, m, 2'd0, md[1], md[0]);
        end

    sweep_wide(2'd1, 400);
    sweep_wide(2'd2, 400);

    // R9 illegal size code
    run_op("R9 illegal size", {16{8'hFF}}, {16{8'hFF}}, 2'd3, 1'b1, 1'b0);

    // R10 idle cycles: outputs hold, strobe low
    run_op("R10 setup", {16{8'hF0}}, {16{8'h20}}, 2'd0, 1'b1, 1'b0);
    hold_y = result_o; hold_f = sat_o;
    op_n_i = '0; op_m_i = {16{8'h55}}; size_i = 2'd3; sub_i = 1'b1;
    repeat (2) @(negedge clk);
    n_checks++;
    if (valid_o !== 1'b0 || err_o !== 1'b0 || result_o !== hold_y || sat_o !== hold_f) begin
      n_fail++;
      $display("FAIL R10 hold: got v=%0b e=%0b y=%h f=%h, exp v=0 e=0 y=%h f=%h",
               valid_o, err_o, result_o, sat_o, hold_y, hold_f);
    end

    // R8 back-to-back strobes
    @(negedge clk);
    op_n_i = {16{8'd100}}; op_m_i = {16{8'd100}}; size_i = 2'd0;
    unsigned_i = 1'b0; sub_i = 1'b0; valid_i = 1'b1;
    @(negedge clk);
    op_n_i = {16{8'd3}}; op_m_i = {16{8'd1}}; sub_i = 1'b1;
    n_checks++;
    if (valid_o !== 1'b1 || result_o !== {16{8'h7F}} || sat_o !== 16'hFFFF) begin
      n_fail++;
      $display("FAIL R8 first: got v=%0b y=%h f=%h, exp v=1 y=%h f=ffff",
               valid_o, result_o, sat_o, {16{8'h7F}});
    end
    @(negedge clk);
    valid_i = 1'b0;
    n_checks++;
    if (valid_o !== 1'b1 || result_o !== {16{8'd2}} || sat_o !== 16'h0) begin
      n_fail++;
      $display("FAIL R8 second: got v=%0b y=%h f=%h, exp v=1 y=%h f=0000",
               valid_o, result_o, sat_o, {16{8'd2}});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule